// File: doc/BRIEF.md
# Half-Duplex Multi-Wire SPI Slave

This block is a serial slave that answers half-duplex transactions arriving over one chip-select, one serial clock and four data lines. Each transaction is a fixed sequence of phases: an opcode byte, then an address byte when the opcode calls for one, then a turnaround interval in which neither side drives, then data. The opcode selects both the operation and how many data lines carry the address and data phases. A quad-command mode moves the opcode itself onto four lines.

Single-byte register writes and reads reach a small shared register file that local logic can also read and write through a parallel port. Streaming opcodes and their completion opcodes are not buffered here. They are decoded and passed on as one-cycle strobes that carry a kind code and a lane-width code. The serial inputs are sampled by the system clock and edge-detected, so the system clock must run well above the serial clock.

Top module: `spi_hd_slave`

## Requirements
- R1: After synchronous reset, `sd_oe` is 0, `dma_stb` is 0 and every shared register reads 0 on `lp_rdata`.
- R2: The opcode byte is taken MSB first on serial-clock rising edges: one bit per edge on `sd_i[0]` normally, or four bits per edge on `sd_i[3:0]` while quad-command mode is on.
- R3: Opcode bits [7:4] pick the lanes used for the address and data phases: 0x0 gives one lane, 0x5 gives two lanes and 0xA gives four lanes. Bits [3:0] pick the operation: 1 is register write, 2 is register read, 3 is write stream and 4 is read stream. Any other upper nibble is undefined.
- R4: For a register write, the address byte selects the register. Only the first data byte is stored. An address of NREG or more stores nothing, and any later bytes have no effect.
- R5: For a register read, the slave starts driving the selected register MSB first after DUMMY_CYC turnaround rising edges, changing the lines after each serial-clock falling edge. One lane uses `sd_o[1]` with `sd_oe`=0010. Two lanes use `sd_o[1:0]` (bit 1 is the more significant) with `sd_oe`=0011. Four lanes use `sd_o[3:0]` with `sd_oe`=1111. An address of NREG or more reads 0.
- R6: `sd_oe` is 0 during the opcode, address, turnaround and write-data phases, and within 3 system clocks after `cs_n` goes high.
- R7: A stream opcode (3 or 4, with any valid lane nibble) takes an address byte that is ignored. When that byte completes, the block pulses `dma_stb` for one cycle with `dma_kind` 0 (write) or 1 (read) and `dma_lanes` 0, 1 or 2 for one, two or four lanes.
- R8: Opcode 0x07 pulses `dma_stb` with kind 2, and opcode 0x08 pulses it with kind 3. In both cases `dma_lanes` is 0, the strobe comes when the opcode completes, and there is no address phase.
- R9: Opcode 0x38 turns quad-command mode on and opcode 0xDD turns it off. The new mode applies from the next transaction.
- R10: An undefined opcode causes the rest of the transaction to be ignored: no register changes, no strobe and no drive.
- R11: Raising `cs_n` in any phase aborts it and discards any partial byte. The next transaction starts with the opcode.
- R12: `lp_rdata` shows register `lp_addr` combinationally, and `lp_we` writes `lp_wdata` to it. If a serial write and a local write hit the same register in the same cycle, the serial write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock from the master |
| cs_n | input | 1 | Active-low chip select |
| sd_i | input | 4 | Data lines as seen from the pins |
| sd_o | output | 4 | Data the slave drives onto the lines |
| sd_oe | output | 4 | Per-line output enables |
| lp_we | input | 1 | Local register write strobe |
| lp_addr | input | AW | Local register index |
| lp_wdata | input | 8 | Local write data |
| lp_rdata | output | 8 | Local read data |
| dma_stb | output | 1 | Stream event strobe |
| dma_kind | output | 2 | 0 write stream, 1 read stream, 2 write done, 3 read done |
| dma_lanes | output | 2 | Lane width of the stream: 0 one, 1 two, 2 four |

## Verification
A serial register write and a local-port write can land on the same register in the same clock. To provoke this, the bench times the local write strobe to the exact cycle in which the last data bit of a serial write commits. It counts the synchronizer and edge-detect registers from the final rising serial-clock edge to find that cycle. The stored value is then read back through the local port and must equal the serial byte, not the local one.

// File: rtl/spi_hd_pkg.sv
package spi_hd_pkg;

    typedef enum logic [2:0] {
        PH_CMD   = 3'd0,
        PH_ADDR  = 3'd1,
        PH_DUMMY = 3'd2,
        PH_DATA  = 3'd3,
        PH_SKIP  = 3'd4
    } phase_t;

    typedef enum logic [1:0] {
        LW_1 = 2'd0,
        LW_2 = 2'd1,
        LW_4 = 2'd2
    } lanes_t;

    typedef enum logic [2:0] {
        OP_WREG, OP_RREG, OP_WSTR, OP_RSTR, OP_NONE
    } op_t;

    typedef enum logic [1:0] {
        DK_WSTREAM = 2'd0,
        DK_RSTREAM = 2'd1,
        DK_WDONE   = 2'd2,
        DK_RDONE   = 2'd3
    } dkind_t;

    typedef struct packed {
        op_t    op;
        lanes_t lanes;
    } cmd_t;

    localparam logic [7:0] OPC_WDONE = 8'h07;
    localparam logic [7:0] OPC_RDONE = 8'h08;
    localparam logic [7:0] OPC_QON   = 8'h38;
    localparam logic [7:0] OPC_QOFF  = 8'hDD;

    function automatic cmd_t decode_cmd(input logic [7:0] c);
        cmd_t r;
        r.op    = OP_NONE;
        r.lanes = LW_1;
        case (c[7:4])
            4'h0:    r.lanes = LW_1;
            4'h5:    r.lanes = LW_2;
            4'hA:    r.lanes = LW_4;
            default: return r;
        endcase
        case (c[3:0])
            4'h1:    r.op = OP_WREG;
            4'h2:    r.op = OP_RREG;
            4'h3:    r.op = OP_WSTR;
            4'h4:    r.op = OP_RSTR;
            default: r.op = OP_NONE;
        endcase
        return r;
    endfunction

    function automatic logic [3:0] lane_count(input lanes_t l);
        case (l)
            LW_2:    return 4'd2;
            LW_4:    return 4'd4;
            default: return 4'd1;
        endcase
    endfunction

    function automatic logic [7:0] merge_in(input logic [7:0] sh, input logic [3:0] din,
                                            input lanes_t l);
        case (l)
            LW_2:    return {sh[5:0], din[1:0]};
            LW_4:    return {sh[3:0], din[3:0]};
            default: return {sh[6:0], din[0]};
        endcase
    endfunction

    function automatic logic [3:0] drive_lanes(input logic [7:0] tx, input lanes_t l);
        case (l)
            LW_2:    return {2'b00, tx[7:6]};
            LW_4:    return tx[7:4];
            default: return {2'b00, tx[7], 1'b0};
        endcase
    endfunction

    function automatic logic [3:0] lane_mask(input lanes_t l);
        case (l)
            LW_2:    return 4'b0011;
            LW_4:    return 4'b1111;
            default: return 4'b0010;
        endcase
    endfunction

endpackage

// File: rtl/spi_hd_sync.sv
module spi_hd_sync #(
    parameter int              W      = 6,
    parameter logic [W-1:0]    RSTVAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic [W-1:0] q_prev
);
    logic [W-1:0] st1, st2, st3;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                st1[i] <= RSTVAL[i];
                st2[i] <= RSTVAL[i];
                st3[i] <= RSTVAL[i];
            end else begin
                st1[i] <= d[i];
                st2[i] <= st1[i];
                st3[i] <= st2[i];
            end
        end
    end

    assign q      = st2;
    assign q_prev = st3;
endmodule

// File: rtl/spi_hd_regfile.sv
module spi_hd_regfile #(
    parameter int NREG = 8,
    parameter int DW   = 8,
    parameter int AW   = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          s_we,
    input  logic [AW-1:0] s_waddr,
    input  logic [DW-1:0] s_wdata,
    input  logic [AW-1:0] s_raddr,
    output logic [DW-1:0] s_rdata,
    input  logic          l_we,
    input  logic [AW-1:0] l_addr,
    input  logic [DW-1:0] l_wdata,
    output logic [DW-1:0] l_rdata
);
    logic [DW-1:0] regs [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs[i] <= '0;
            else if (s_we && s_waddr == AW'(i))
                regs[i] <= s_wdata;
            else if (l_we && l_addr == AW'(i))
                regs[i] <= l_wdata;
        end
    end

    assign s_rdata = regs[s_raddr];
    assign l_rdata = regs[l_addr];
endmodule

// File: rtl/spi_hd_engine.sv
module spi_hd_engine
    import spi_hd_pkg::*;
#(
    parameter int NREG      = 8,
    parameter int DUMMY_CYC = 8,
    parameter int AW        = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sel,
    input  logic          sclk_rise,
    input  logic          sclk_fall,
    input  logic [3:0]    din,
    input  logic [7:0]    rd_data,
    output logic [AW-1:0] ra,
    output logic          we,
    output logic [AW-1:0] wa,
    output logic [7:0]    wd,
    output logic [3:0]    out_q,
    output logic [3:0]    oe_q,
    output logic          stb,
    output logic [1:0]    stb_kind,
    output logic [1:0]    stb_lanes,
    output logic [2:0]    phase_o
);
    localparam int DCW = $clog2(DUMMY_CYC + 1);

    phase_t         phase;
    logic           qcmd;
    cmd_t           cur, dec;
    logic [7:0]     sh, nbyte, addr, txsh;
    logic [3:0]     bcnt, txcnt, wb;
    logic [DCW-1:0] dcnt;
    lanes_t         lanes_now;
    logic           last;

    assign lanes_now = (phase == PH_CMD) ? (qcmd ? LW_4 : LW_1) : cur.lanes;
    assign wb        = lane_count(lanes_now);
    assign nbyte     = merge_in(sh, din, lanes_now);
    assign last      = (bcnt + wb) == 4'd8;
    assign dec       = decode_cmd(nbyte);
    assign ra        = addr[AW-1:0];
    assign phase_o   = phase;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_CMD; qcmd <= 1'b0; cur <= '{op: OP_NONE, lanes: LW_1};
            sh <= '0; bcnt <= '0; addr <= '0; dcnt <= '0; txsh <= '0; txcnt <= '0;
            out_q <= '0; oe_q <= '0; we <= 1'b0; wa <= '0; wd <= '0;
            stb <= 1'b0; stb_kind <= '0; stb_lanes <= '0;
        end else begin
            we  <= 1'b0;
            stb <= 1'b0;
            if (!sel) begin
                phase <= PH_CMD;
                bcnt  <= '0;
                oe_q  <= '0;
            end else if (sclk_rise) begin
                case (phase)
                    PH_CMD, PH_ADDR, PH_DATA: begin
                        if (!(phase == PH_DATA && cur.op == OP_RREG)) begin
                            sh   <= nbyte;
                            bcnt <= last ? 4'd0 : bcnt + wb;
                            if (last) begin
                                if (phase == PH_CMD) begin
                                    phase <= PH_SKIP;
                                    if (nbyte == OPC_QON)       qcmd <= 1'b1;
                                    else if (nbyte == OPC_QOFF) qcmd <= 1'b0;
                                    else if (nbyte == OPC_WDONE || nbyte == OPC_RDONE) begin
                                        stb       <= 1'b1;
                                        stb_kind  <= (nbyte == OPC_WDONE) ? DK_WDONE : DK_RDONE;
                                        stb_lanes <= LW_1;
                                    end else if (dec.op != OP_NONE) begin
                                        cur   <= dec;
                                        phase <= PH_ADDR;
                                    end
                                end else if (phase == PH_ADDR) begin
                                    addr <= nbyte;
                                    dcnt <= '0;
                                    case (cur.op)
                                        OP_WREG: phase <= PH_DATA;
                                        OP_RREG: phase <= PH_DUMMY;
                                        OP_WSTR, OP_RSTR: begin
                                            stb       <= 1'b1;
                                            stb_kind  <= (cur.op == OP_WSTR) ? DK_WSTREAM : DK_RSTREAM;
                                            stb_lanes <= cur.lanes;
                                            phase     <= PH_SKIP;
                                        end
                                        default: phase <= PH_SKIP;
                                    endcase
                                end else begin
                                    we    <= ({24'd0, addr} < NREG);
                                    wa    <= addr[AW-1:0];
                                    wd    <= nbyte;
                                    phase <= PH_SKIP;
                                end
                            end
                        end
                    end
                    PH_DUMMY: begin
                        if (dcnt == DCW'(DUMMY_CYC - 1)) begin
                            phase <= PH_DATA;
                            txsh  <= ({24'd0, addr} < NREG) ? rd_data : 8'h00;
                            txcnt <= '0;
                        end else begin
                            dcnt <= dcnt + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end else if (sclk_fall && phase == PH_DATA && cur.op == OP_RREG) begin
                if (txcnt != 4'd8) begin
                    out_q <= drive_lanes(txsh, cur.lanes);
                    oe_q  <= lane_mask(cur.lanes);
                    txsh  <= txsh << wb;
                    txcnt <= txcnt + wb;
                end else begin
                    oe_q <= '0;
                end
            end
        end
    end
endmodule

// File: rtl/spi_hd_slave.sv
module spi_hd_slave
    import spi_hd_pkg::*;
#(
    parameter  int NREG      = 8,
    parameter  int DUMMY_CYC = 8,
    localparam int AW        = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sclk,
    input  logic          cs_n,
    input  logic [3:0]    sd_i,
    output logic [3:0]    sd_o,
    output logic [3:0]    sd_oe,
    input  logic          lp_we,
    input  logic [AW-1:0] lp_addr,
    input  logic [7:0]    lp_wdata,
    output logic [7:0]    lp_rdata,
    output logic          dma_stb,
    output logic [1:0]    dma_kind,
    output logic [1:0]    dma_lanes
);
    logic [5:0]    s_now, s_prev;
    logic          cs_sel, sclk_rise, sclk_fall;
    logic          spi_we;
    logic [AW-1:0] spi_wa, spi_ra;
    logic [7:0]    spi_wd, spi_rd;
    logic [3:0]    oe_raw;
    logic [2:0]    eng_phase;

    spi_hd_sync #(.W(6), .RSTVAL(6'b010000)) u_sync (
        .clk(clk), .rst(rst), .d({sclk, cs_n, sd_i}), .q(s_now), .q_prev(s_prev)
    );

    assign cs_sel    = ~s_now[4];
    assign sclk_rise =  s_now[5] & ~s_prev[5];
    assign sclk_fall = ~s_now[5] &  s_prev[5];

    spi_hd_engine #(.NREG(NREG), .DUMMY_CYC(DUMMY_CYC), .AW(AW)) u_eng (
        .clk(clk), .rst(rst), .sel(cs_sel), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
        .din(s_now[3:0]), .rd_data(spi_rd), .ra(spi_ra),
        .we(spi_we), .wa(spi_wa), .wd(spi_wd),
        .out_q(sd_o), .oe_q(oe_raw),
        .stb(dma_stb), .stb_kind(dma_kind), .stb_lanes(dma_lanes),
        .phase_o(eng_phase)
    );

    spi_hd_regfile #(.NREG(NREG), .DW(8), .AW(AW)) u_rf (
        .clk(clk), .rst(rst),
        .s_we(spi_we), .s_waddr(spi_wa), .s_wdata(spi_wd),
        .s_raddr(spi_ra), .s_rdata(spi_rd),
        .l_we(lp_we), .l_addr(lp_addr), .l_wdata(lp_wdata), .l_rdata(lp_rdata)
    );

    assign sd_oe = oe_raw & {4{cs_sel}};
endmodule

// File: rtl/spi_hd_slave_chk.sv
module spi_hd_slave_chk
    import spi_hd_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       cs_n,
    input logic       sel,
    input logic [3:0] sd_oe,
    input logic       dma_stb,
    input logic [2:0] phase,
    input logic       spi_we
);
    logic [1:0] up;
    always_ff @(posedge clk) begin
        if (rst)           up <= '0;
        else if (up != 2'd3) up <= up + 1'b1;
    end

    // R6: released lines once chip select has been high for a while
    a_r6_release_on_deselect: assert property (@(posedge clk) disable iff (rst)
        (up >= 2'd2 && cs_n && $past(cs_n) && $past(cs_n, 2)) |-> sd_oe == 4'b0000);

    // R6: turnaround interval is never driven
    a_r6_quiet_dummy: assert property (@(posedge clk) disable iff (rst)
        phase == 3'(PH_DUMMY) |-> sd_oe == 4'b0000);

    // R5: enables take only the three lane patterns
    a_r5_oe_legal: assert property (@(posedge clk) disable iff (rst)
        sd_oe == 4'b0000 || sd_oe == 4'b0010 || sd_oe == 4'b0011 || sd_oe == 4'b1111);

    // R5: drive only in the data phase
    a_r5_drive_in_data: assert property (@(posedge clk) disable iff (rst)
        sd_oe != 4'b0000 |-> phase == 3'(PH_DATA));

    // R7: stream strobe lasts one cycle
    a_r7_strobe_single: assert property (@(posedge clk) disable iff (rst)
        dma_stb |=> !dma_stb);

    // R10: an ignored transaction commits no register write
    a_r10_skip_no_write: assert property (@(posedge clk) disable iff (rst)
        (up >= 2'd1 && phase == 3'(PH_SKIP) && $past(phase) == 3'(PH_SKIP)) |-> !spi_we);

    // R11: deselect returns the decoder to the opcode phase
    a_r11_abort_to_cmd: assert property (@(posedge clk) disable iff (rst)
        !sel |=> phase == 3'(PH_CMD));
endmodule

bind spi_hd_slave spi_hd_slave_chk u_chk (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sel(cs_sel), .sd_oe(sd_oe),
    .dma_stb(dma_stb), .phase(eng_phase), .spi_we(spi_we)
);

// File: tb/tb_spi_hd_slave.sv
module tb_spi_hd_slave;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;
    localparam int NREG       = 8;
    localparam int DUMMY      = 8;
    localparam int AW         = 3;

    logic          clk = 1'b0, rst = 1'b1;
    logic          sclk = 1'b0, cs_n = 1'b1;
    logic [3:0]    sd_i = '0;
    logic [3:0]    sd_o, sd_oe;
    logic          lp_we = 1'b0;
    logic [AW-1:0] lp_addr = '0;
    logic [7:0]    lp_wdata = '0, lp_rdata;
    logic          dma_stb;
    logic [1:0]    dma_kind, dma_lanes;

    int   compared = 0, mismatched = 0;
    bit   quiet = 1'b1, done = 1'b0;
    logic [7:0] mreg [NREG];
    int   exp_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_hd_slave #(.NREG(NREG), .DUMMY_CYC(DUMMY)) dut (
        .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .sd_i(sd_i), .sd_o(sd_o), .sd_oe(sd_oe),
        .lp_we(lp_we), .lp_addr(lp_addr), .lp_wdata(lp_wdata), .lp_rdata(lp_rdata),
        .dma_stb(dma_stb), .dma_kind(dma_kind), .dma_lanes(dma_lanes)
    );

    task automatic chk(input string rq, input int act, input int exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    // per-clock reference comparisons
    always @(negedge clk) begin
        if (!rst) begin
            if (quiet) chk("R6 lines released outside read data", sd_oe, 0);
            if (dma_stb) begin
                if (exp_q.size() == 0) chk("R10 unexpected stream strobe", 1, 0);
                else chk("R7 R8 strobe kind/lanes", {dma_kind, dma_lanes}, exp_q.pop_front());
            end
        end
    end

    task automatic sedge(input logic [3:0] din, output logic [3:0] dout, output logic [3:0] oe);
        sd_i = din;
        repeat (HALF) @(negedge clk);
        dout = sd_o; oe = sd_oe;
        sclk = 1'b1;
        repeat (HALF) @(negedge clk);
        sclk = 1'b0;
    endtask

    function automatic logic [3:0] chunk(input logic [7:0] b, input int w, input int i);
        logic [7:0] s = b >> (8 - w * (i + 1));
        return (w == 1) ? {3'b0, s[0]} : (w == 2) ? {2'b0, s[1:0]} : s[3:0];
    endfunction

    task automatic tbegin(); cs_n = 1'b0; repeat (HALF) @(negedge clk); endtask
    task automatic tend();
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1; sd_i = '0;
        repeat (HALF) @(negedge clk);
        quiet = 1'b1;
    endtask

    task automatic send_byte(input logic [7:0] b, input int w);
        logic [3:0] d, o;
        for (int i = 0; i < 8 / w; i++) sedge(chunk(b, w, i), d, o);
    endtask

    task automatic reg_write(input logic [7:0] op, input logic [7:0] a, input logic [7:0] d,
                             input int w, input int cw);
        tbegin(); send_byte(op, cw); send_byte(a, w); send_byte(d, w); tend();
        if (a < NREG) mreg[a] = d;
    endtask

    task automatic reg_read(input logic [7:0] op, input logic [7:0] a, input int w, input int cw,
                            input string rq, output logic [7:0] v);
        logic [3:0] d, o;
        logic [3:0] m = (w == 1) ? 4'b0010 : (w == 2) ? 4'b0011 : 4'b1111;
        tbegin(); send_byte(op, cw); send_byte(a, w);
        for (int i = 0; i < DUMMY; i++) begin
            sedge(4'h0, d, o);
            chk("R6 no drive in turnaround", o, 0);
        end
        quiet = 1'b0;
        v = '0;
        for (int i = 0; i < 8 / w; i++) begin
            sedge(4'h0, d, o);
            chk({rq, " lane enables"}, o, m);
            v = (w == 1) ? {v[6:0], d[1]} : (w == 2) ? {v[5:0], d[1:0]} : {v[3:0], d[3:0]};
        end
        tend();
    endtask

    task automatic peek(input int a, output logic [7:0] v);
        lp_addr = AW'(a); #1; v = lp_rdata;
    endtask

    task automatic check_all(input string rq);
        logic [7:0] v;
        for (int a = 0; a < NREG; a++) begin peek(a, v); chk(rq, v, mreg[a]); end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk("watchdog expired", 1, 0);
        finish_run();
    end

    initial begin
        logic [7:0] v;
        logic [3:0] d, o;
        for (int a = 0; a < NREG; a++) mreg[a] = 8'h00;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // R1 reset state
        chk("R1 oe after reset", sd_oe, 0);
        chk("R1 strobe after reset", dma_stb, 0);
        check_all("R1 registers zero");

        // R2 R4 single-lane write, R5 single-lane read
        reg_write(8'h01, 8'h03, 8'h5A, 1, 1);
        peek(3, v); chk("R4 single-lane write", v, 8'h5A);
        reg_read(8'h02, 8'h03, 1, 1, "R5 1-lane", v);
        chk("R5 single-lane read value", v, 8'h5A);

        // R3 quad write, dual and quad read
        reg_write(8'hA1, 8'h05, 8'hC3, 4, 1);
        peek(5, v); chk("R3 quad write", v, 8'hC3);
        reg_read(8'h52, 8'h05, 2, 1, "R5 2-lane", v);
        chk("R3 dual read value", v, 8'hC3);
        reg_read(8'hA2, 8'h05, 4, 1, "R5 4-lane", v);
        chk("R3 quad read value", v, 8'hC3);
        reg_write(8'h51, 8'h01, 8'h96, 2, 1);
        peek(1, v); chk("R3 dual write", v, 8'h96);

        // R12 local write then serial read
        @(negedge clk); lp_addr = 3'd2; lp_wdata = 8'h77; lp_we = 1'b1;
        @(negedge clk); lp_we = 1'b0; mreg[2] = 8'h77;
        reg_read(8'h02, 8'h02, 1, 1, "R12 local", v);
        chk("R12 local write visible serially", v, 8'h77);

        // R4 out of range and extra bytes
        reg_write(8'h01, 8'h09, 8'hAB, 1, 1);
        check_all("R4 out-of-range write ignored");
        reg_read(8'h02, 8'h09, 1, 1, "R5 range", v);
        chk("R5 out-of-range read is zero", v, 0);
        tbegin(); send_byte(8'h01, 1); send_byte(8'h00, 1); send_byte(8'h11, 1);
        send_byte(8'h22, 1); tend(); mreg[0] = 8'h11;
        check_all("R4 only first byte stored");

        // R7 stream commands
        exp_q.push_back({2'd0, 2'd0});
        tbegin(); send_byte(8'h03, 1); send_byte(8'h05, 1); send_byte(8'h44, 1); tend();
        exp_q.push_back({2'd1, 2'd2});
        tbegin(); send_byte(8'hA4, 1); send_byte(8'h05, 4); tend();
        exp_q.push_back({2'd0, 2'd1});
        tbegin(); send_byte(8'h53, 1); send_byte(8'h01, 2); tend();
        chk("R7 all stream strobes seen", exp_q.size(), 0);
        check_all("R7 stream address ignored");

        // R8 completion opcodes
        exp_q.push_back({2'd2, 2'd0});
        tbegin(); send_byte(8'h07, 1); tend();
        exp_q.push_back({2'd3, 2'd0});
        tbegin(); send_byte(8'h08, 1); tend();
        chk("R8 completion strobes seen", exp_q.size(), 0);

        // R10 undefined opcodes
        tbegin(); send_byte(8'h99, 1); send_byte(8'h03, 1); send_byte(8'hFF, 1); tend();
        tbegin(); send_byte(8'h56, 1); send_byte(8'h05, 2); send_byte(8'hFF, 2); tend();
        tbegin(); send_byte(8'h32, 1); send_byte(8'h05, 1);
        for (int i = 0; i < 16; i++) sedge(4'h0, d, o);
        tend();
        check_all("R10 undefined opcode no effect");

        // R11 abort mid data then fresh transaction
        tbegin(); send_byte(8'h01, 1); send_byte(8'h04, 1);
        for (int i = 0; i < 4; i++) sedge({3'b0, 1'b1}, d, o);
        tend();
        peek(4, v); chk("R11 aborted write discarded", v, mreg[4]);
        tbegin(); send_byte(8'h01, 1);
        for (int i = 0; i < 3; i++) sedge(4'h1, d, o);
        tend();
        reg_write(8'h01, 8'h04, 8'h3C, 1, 1);
        peek(4, v); chk("R11 next transaction starts at opcode", v, 8'h3C);

        // R9 quad-command mode
        tbegin(); send_byte(8'h38, 1); tend();
        reg_write(8'hA1, 8'h06, 8'hE1, 4, 4);
        peek(6, v); chk("R9 quad opcode write", v, 8'hE1);
        reg_read(8'h02, 8'h06, 1, 4, "R9 quad-opcode", v);
        chk("R9 quad opcode read", v, 8'hE1);
        tbegin(); send_byte(8'hDD, 4); tend();
        reg_read(8'h02, 8'h06, 1, 1, "R9 exit", v);
        chk("R9 single opcode after exit", v, 8'hE1);

        // R12 same-cycle collision: serial write wins
        tbegin(); send_byte(8'h01, 1); send_byte(8'h07, 1);
        for (int i = 0; i < 7; i++) sedge(chunk(8'h5D, 1, i), d, o);
        sd_i = chunk(8'h5D, 1, 7);
        repeat (HALF) @(negedge clk);
        sclk = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk); lp_addr = 3'd7; lp_wdata = 8'hEE; lp_we = 1'b1;
        @(negedge clk); lp_we = 1'b0;
        repeat (HALF) @(negedge clk);
        sclk = 1'b0;
        tend(); mreg[7] = 8'h5D;
        peek(7, v); chk("R12 serial write wins collision", v, 8'h5D);
        check_all("R12 final register image");

        finish_run();
    end
endmodule